// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block keeps the interrupt status flags for a 10-bit timer that has three compare channels (A, B and D) and an overflow event. It also provides the request lines that the interrupt controller samples. Compare-match strobes set the compare flags. The overflow flag is set by one of two counter-position strobes, and the current waveform mode decides which one. Single-slope modes use the strobe that marks TOP wrapping to BOTTOM. Dual-slope phase-and-frequency-correct mode uses the strobe that marks zero being loaded into the counter.

Software clears a flag by writing 1 to its bit. The clear mask passes through one pipeline register, so the flag drops one cycle after the write. A flag also clears when its vector is serviced, which the interrupt controller signals with an acknowledge pulse. The four remaining bits of the 8-bit register belong to a neighbouring timer. Each of them is a plain flag with its own external set strobe, and each is cleared by writing 1 to it.

A request line is raised while the global enable, that source's enable and that source's flag are all 1. When a set and a clear land on the same cycle, the set wins, so no event is dropped.

Top module: `tmr_irq_flags`

## Requirements
- R1: After reset, all eight bits of `flags_o` are 0 and every bit of `irq_o` is 0.
- R2: Register layout: bit 7 is channel D compare, bit 6 is channel A compare, bit 5 is channel B compare and bit 2 is overflow. The neighbour flags map as `ext_set_i[0]`→bit 0, `ext_set_i[1]`→bit 1, `ext_set_i[2]`→bit 3 and `ext_set_i[3]`→bit 4.
- R3: A one-cycle compare strobe (`cmp_a_i`, `cmp_b_i` or `cmp_d_i`) sets its flag at the next clock edge, and the flag then holds at 1.
- R4: When `mode_i` is 2'b00 (normal) or 2'b01 (fast PWM), `at_top_i` sets the overflow flag and `at_bottom_i` has no effect on it.
- R5: When `mode_i` is 2'b10 (phase-and-frequency correct) or 2'b11 (treated the same way), `at_bottom_i` sets the overflow flag and `at_top_i` has no effect on it.
- R6: A write with `wr_en_i`=1 clears every flag whose `wr_data_i` bit is 1. The flag still reads 1 after the write edge and reads 0 after the following edge.
- R7: A `wr_data_i` bit of 0 leaves its flag unchanged, and a write never sets a flag.
- R8: A one-cycle `ack_i[k]` pulse clears source k's flag at the next edge. Sources are indexed 0=A, 1=B, 2=D, 3=overflow.
- R9: When a set strobe coincides with a clear, whether from a delayed write or from an acknowledge, the flag ends up at 1.
- R10: `irq_o[k]` equals `gie_i & irq_en_i[k] & flag_k`, using the same source order as R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_a_i | input | 1 | Channel A compare-match strobe |
| cmp_b_i | input | 1 | Channel B compare-match strobe |
| cmp_d_i | input | 1 | Channel D compare-match strobe |
| at_top_i | input | 1 | Counter at TOP and wrapping to BOTTOM |
| at_bottom_i | input | 1 | Zero being clocked into the counter |
| mode_i | input | 2 | Waveform mode; bit 1 set selects dual-slope |
| ext_set_i | input | 4 | Set strobes for the neighbour timer's flags |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data; a 1 bit clears that flag |
| gie_i | input | 1 | Global interrupt enable |
| irq_en_i | input | 4 | Per-source enables (A, B, D, overflow) |
| ack_i | input | 4 | Per-source service acknowledge pulses |
| flags_o | output | 8 | Readable flag register |
| irq_o | output | 4 | Per-source interrupt requests |

## Verification
Each set strobe is driven alone, and the bench checks that exactly the expected bit position rises. This separates a correct layout from swapped bits. The overflow event is tried in all four modes, once with the TOP strobe and once with the BOTTOM strobe, which exposes a wrong mode decode or a wrong strobe selection. Clears are sampled on both edges after a write, which tells a missing pipeline delay apart from an extra one. Sets are placed on the exact clear cycle to confirm that the set has priority. The request gating is swept over all enable combinations, with every flag set and again with only half of them set.

// File: rtl/tif_pkg.sv
package tif_pkg;
  localparam int REG_W  = 8;
  localparam int N_SRC  = 4;
  localparam int N_EXT  = 4;

  typedef enum logic [1:0] {
    WM_NORMAL   = 2'b00,
    WM_FAST     = 2'b01,
    WM_PFC      = 2'b10,
    WM_PFC_ALT  = 2'b11
  } wave_mode_e;

  // source order: A, B, D, overflow
  localparam int SRC_POS [N_SRC] = '{6, 5, 7, 2};
  localparam int EXT_POS [N_EXT] = '{0, 1, 3, 4};
  localparam int OVF_POS = 2;
endpackage

// File: rtl/tif_ovf_sel.sv
module tif_ovf_sel
  import tif_pkg::*;
(
  input  logic       at_top_i,
  input  logic       at_bottom_i,
  input  logic [1:0] mode_i,
  output logic       ovf_o
);
  wave_mode_e mode;
  assign mode = wave_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      WM_NORMAL, WM_FAST: ovf_o = at_top_i;
      default:            ovf_o = at_bottom_i;
    endcase
  end
endmodule

// File: rtl/tif_clr_pipe.sv
module tif_clr_pipe #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] clr_o
);
  logic [W-1:0] clr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clr_q <= '0;
    else         clr_q <= wr_en_i ? wr_data_i : '0;
  end

  assign clr_o = clr_q;

  AST_CLR_ONLY_AFTER_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (clr_q == '0)); // R7
endmodule

// File: rtl/tif_flag_bit.sv
module tif_flag_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // set has priority so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o); // R9
  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o); // R6
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(flag_o)); // R7
endmodule

// File: rtl/tif_irq_gate.sv
module tif_irq_gate #(
  parameter int N = 4
) (
  input  logic         gie_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] flag_i,
  output logic [N-1:0] irq_o
);
  for (genvar k = 0; k < N; k++) begin : g_gate
    assign irq_o[k] = gie_i & en_i[k] & flag_i[k];
  end
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
  import tif_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_a_i,
  input  logic             cmp_b_i,
  input  logic             cmp_d_i,
  input  logic             at_top_i,
  input  logic             at_bottom_i,
  input  logic [1:0]       mode_i,
  input  logic [N_EXT-1:0] ext_set_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             gie_i,
  input  logic [N_SRC-1:0] irq_en_i,
  input  logic [N_SRC-1:0] ack_i,
  output logic [REG_W-1:0] flags_o,
  output logic [N_SRC-1:0] irq_o
);
  logic             ovf_evt;
  logic [N_SRC-1:0] src_set;
  logic [N_SRC-1:0] src_flag;
  logic [REG_W-1:0] set_vec, ack_vec, wr_clr;

  tif_ovf_sel i_ovf_sel (
    .at_top_i    (at_top_i),
    .at_bottom_i (at_bottom_i),
    .mode_i      (mode_i),
    .ovf_o       (ovf_evt)
  );

  tif_clr_pipe #(.W(REG_W)) i_clr_pipe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .clr_o     (wr_clr)
  );

  assign src_set = {ovf_evt, cmp_d_i, cmp_b_i, cmp_a_i};

  always_comb begin
    set_vec = '0;
    ack_vec = '0;
    for (int k = 0; k < N_SRC; k++) begin
      set_vec[SRC_POS[k]] = src_set[k];
      ack_vec[SRC_POS[k]] = ack_i[k];
    end
    for (int k = 0; k < N_EXT; k++) begin
      set_vec[EXT_POS[k]] = ext_set_i[k];
    end
  end

  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    tif_flag_bit i_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_vec[b]),
      .clr_i  (wr_clr[b] | ack_vec[b]),
      .flag_o (flags_o[b])
    );
  end

  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    assign src_flag[k] = flags_o[SRC_POS[k]];
  end

  tif_irq_gate #(.N(N_SRC)) i_irq_gate (
    .gie_i  (gie_i),
    .en_i   (irq_en_i),
    .flag_i (src_flag),
    .irq_o  (irq_o)
  );

  AST_OVF_SINGLE_IGNORES_BOTTOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i[1] && !at_top_i && !flags_o[OVF_POS]) |=> !flags_o[OVF_POS]); // R4
  AST_OVF_DUAL_IGNORES_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1] && !at_bottom_i && !flags_o[OVF_POS]) |=> !flags_o[OVF_POS]); // R5
  AST_ACK_CLEARS_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i[0] && !cmp_a_i) |=> !flags_o[SRC_POS[0]]); // R8
  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |-> (irq_o == '0)); // R10
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (flags_o == '0)); // R1
endmodule

// File: tb/test_tmr_irq_flags.sv
module test_tmr_irq_flags;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_a = 0, cmp_b = 0, cmp_d = 0, at_top = 0, at_bot = 0;
  logic [1:0] mode = 2'b00;
  logic [3:0] ext_set = '0;
  logic       wr_en = 0;
  logic [7:0] wr_data = '0;
  logic       gie = 0;
  logic [3:0] irq_en = '0, ack = '0;
  logic [7:0] flags;
  logic [3:0] irq;

  int total = 0;
  int bad = 0;
  int src_pos [4] = '{6, 5, 7, 2};
  int ext_pos [4] = '{0, 1, 3, 4};

  always #2 clk = ~clk;

  tmr_irq_flags i_tmr_irq_flags (
    .clk_i(clk), .rst_ni(rst_n), .cmp_a_i(cmp_a), .cmp_b_i(cmp_b), .cmp_d_i(cmp_d),
    .at_top_i(at_top), .at_bottom_i(at_bot), .mode_i(mode), .ext_set_i(ext_set),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .gie_i(gie), .irq_en_i(irq_en),
    .ack_i(ack), .flags_o(flags), .irq_o(irq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_src(int k, logic v);
    case (k)
      0: cmp_a = v;
      1: cmp_b = v;
      2: cmp_d = v;
      default: at_top = v;
    endcase
  endtask

  task automatic clear_all();
    wr_en = 1; wr_data = 8'hFF; tick();
    wr_en = 0; wr_data = '0; tick();
  endtask

  task automatic set_all();
    mode = 2'b00;
    cmp_a = 1; cmp_b = 1; cmp_d = 1; at_top = 1; ext_set = 4'hF; tick();
    cmp_a = 0; cmp_b = 0; cmp_d = 0; at_top = 0; ext_set = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(); tick();
    check("R1 flags", flags, 8'h00);
    check("R1 irq", {4'h0, irq}, 8'h00);
    rst_n = 1; tick();
    check("R1 flags after release", flags, 8'h00);

    // R3 / R2: each compare strobe sets its own bit only
    for (int k = 0; k < 3; k++) begin
      clear_all();
      set_src(k, 1); tick(); set_src(k, 0);
      check("R3 R2 compare set", flags, 8'(1 << src_pos[k]));
      tick();
      check("R3 compare hold", flags, 8'(1 << src_pos[k]));
    end

    // R2: neighbour flags
    for (int e = 0; e < 4; e++) begin
      clear_all();
      ext_set[e] = 1; tick(); ext_set = '0;
      check("R2 ext bit", flags, 8'(1 << ext_pos[e]));
    end

    // R4 / R5: overflow point per mode
    for (int m = 0; m < 4; m++) begin
      for (int ev = 0; ev < 2; ev++) begin
        clear_all();
        mode = 2'(m);
        if (ev == 0) at_top = 1; else at_bot = 1;
        tick();
        at_top = 0; at_bot = 0;
        if (m[1]) check("R5 dual-slope overflow", flags, (ev == 1) ? 8'h04 : 8'h00);
        else      check("R4 single-slope overflow", flags, (ev == 0) ? 8'h04 : 8'h00);
      end
    end
    mode = 2'b00;

    // R6: one-cycle latency on write-one clear, per bit
    for (int b = 0; b < 8; b++) begin
      clear_all();
      set_all();
      wr_en = 1; wr_data = 8'(1 << b); tick();
      wr_en = 0; wr_data = '0;
      check("R6 still set after write edge", flags, 8'hFF);
      tick();
      check("R6 cleared next edge", flags, 8'hFF & ~8'(1 << b));
    end

    // R7: zero writes have no effect; writes never set
    clear_all();
    set_all();
    wr_en = 1; wr_data = 8'h00; tick(); wr_en = 0; tick();
    check("R7 write zero keeps", flags, 8'hFF);
    wr_en = 1; wr_data = 8'h5A; tick(); wr_en = 0; wr_data = '0; tick();
    check("R7 partial write", flags, 8'hA5);
    clear_all();
    wr_en = 1; wr_data = 8'hFF; tick(); wr_en = 0; wr_data = '0; tick();
    check("R7 write never sets", flags, 8'h00);

    // R8: acknowledge clears one source
    for (int k = 0; k < 4; k++) begin
      clear_all();
      set_all();
      ack[k] = 1; tick(); ack = '0;
      check("R8 ack clear", flags, 8'hFF & ~8'(1 << src_pos[k]));
    end

    // R9: set wins over delayed write clear and over ack
    clear_all();
    cmp_a = 1; tick(); cmp_a = 0;
    wr_en = 1; wr_data = 8'h40; tick(); wr_en = 0; wr_data = '0;
    cmp_a = 1; tick(); cmp_a = 0;
    check("R9 set over write clear", flags, 8'h40);
    tick();
    check("R9 set over write clear hold", flags, 8'h40);
    clear_all();
    cmp_d = 1; tick();
    ack[2] = 1; tick(); cmp_d = 0; ack = '0;
    check("R9 set over ack", flags, 8'h80);
    clear_all();
    at_top = 1; ack[3] = 1; tick(); at_top = 0; ack = '0;
    check("R9 set over ack from clear", flags, 8'h04);

    // R10: request gating sweep
    for (int pat = 0; pat < 2; pat++) begin
      clear_all();
      set_all();
      if (pat == 1) begin
        ack = 4'b1010; tick(); ack = '0; // leaves A and D set
      end
      for (int g = 0; g < 2; g++) begin
        for (int en = 0; en < 16; en++) begin
          gie = g[0]; irq_en = 4'(en); #1;
          check("R10 irq gate", {4'h0, irq},
                {4'h0, (g[0] ? 4'(en) : 4'h0) & ((pat == 1) ? 4'b0101 : 4'b1111)});
        end
      end
    end
    gie = 0; irq_en = '0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule